// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the control engine of a single DMA channel that works through a chain of descriptors held in memory. Each descriptor is 32 bytes long and 32-byte aligned, and occupies eight 32-bit words. Software loads the address of the first descriptor, enables the channel and writes the doorbell register. The engine then reads the words of the descriptor that it needs over a request/grant memory port. It hands the source address, destination address and byte count to an external data mover and waits for the mover to finish.

When a transfer is done, the engine performs the write-back that the descriptor asks for. That can be a status word written into the descriptor, an update of its command word that clears the valid flag, or both. It then sets the channel's interrupt-pending flag and moves on to the descriptor named by the next-pointer word. A descriptor whose valid flag is clear halts the channel. The next doorbell write fetches again from the same address, so software can repair the descriptor in place and restart.

A small register file gives software access to the channel. It holds the enable bit and the descriptor pointer, and it provides the doorbell, the pending flag (cleared by writing 1), a status word and the remaining byte count of the last completed descriptor.

Top module: `chain_dma_seq`

## Requirements
- R1: After reset, every register reads 0. mem_req, mv_start and irq_out are 0.
- R2: Any write to register offset 2 (the doorbell) sets status bit 2. The channel leaves idle only while config bit 0 (offset 0) is 1. Status bit 2 clears when the fetch begins.
- R3: The engine reads descriptor words 0 (command), 1 (count), 2 (source), 4 (destination) and 7 (next), each at the descriptor base plus 4 times the word index. It then pulses mv_start for one cycle, with mv_src = word 2, mv_dst = word 4 and mv_count = word 1 bits 21:0.
- R4: A command word with bit 31 clear stops the channel. Status (offset 4) then reads 1: bit 0 halted = 1, bit 1 descriptor-valid = 0. No mover start occurs and the pointer does not move. The next doorbell fetches again from the same pointer.
- R5: Command bits 1:0 select what is written to descriptor word 6 after the transfer. The values are: 0 = nothing, 1 = the channel status word, 2 = the command word with bit 31 cleared, 3 = the remaining count from mv_remain, zero-extended.
- R6: When command bit 2 is 1, the command word with bit 31 cleared is written back to word 0. This happens after any word 6 write.
- R7: Every completed descriptor sets bit 0 of offset 3 (the pending flag), whatever the value of command bit 8. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: irq_out is the pending flag ANDed with command bit 8 of the last completed descriptor.
- R9: The pointer (offset 1) becomes word 7 bits 26:0 shifted left by 5, and the channel goes on to that descriptor while enabled. Pointer writes ignore address bits 4:0.
- R10: Offset 5 holds the remaining count that the mover reported for the last completed descriptor.
- R11: A memory request keeps its address and direction until it is granted. There is no memory request while the mover is busy. All write-backs of a descriptor complete before the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; read data is valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | One-cycle pulse that starts the data mover |
| mv_src | output | 32 | Source address for the mover |
| mv_dst | output | 32 | Destination address for the mover |
| mv_count | output | 22 | Byte count for the mover |
| mv_done | input | 1 | Mover finished (one-cycle pulse) |
| mv_remain | input | 22 | Bytes left untransferred, valid with mv_done |
| irq_out | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach from the ports is the restart of a halted channel from a descriptor that software has repaired, with the pending flag and the byte count left over from an earlier descriptor. The bench builds a sixteen-descriptor chain that covers every combination of write-back select, clear-valid and interrupt enable, and that ends on an invalid descriptor. It rings the doorbell again on the still-invalid descriptor. It then makes that descriptor valid in memory and rings once more. The memory model varies its grant latency by word address, and the mover model varies its latency by descriptor. This places write-backs, grants and completions at different cycle offsets.

// File: rtl/chain_dma_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the linked-descriptor DMA channel sequencer.
// Assumes 32-bit descriptor words and a 32-bit register data path.
package chain_dma_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_LAUNCH,
        SQ_MOVE,
        SQ_WB_STAT,
        SQ_WB_CLR,
        SQ_RETIRE
    } seq_state_e;

    typedef enum logic [1:0] {
        WB_NONE   = 2'd0,
        WB_CHSTAT = 2'd1,
        WB_CMD    = 2'd2,
        WB_REMAIN = 2'd3
    } wb_sel_e;

    // register word offsets
    localparam logic [2:0] RA_CFG  = 3'd0;
    localparam logic [2:0] RA_PTR  = 3'd1;
    localparam logic [2:0] RA_BELL = 3'd2;
    localparam logic [2:0] RA_IRQ  = 3'd3;
    localparam logic [2:0] RA_STAT = 3'd4;
    localparam logic [2:0] RA_BCNT = 3'd5;

    // command word bit positions
    localparam int CMD_VALID_BIT = 31;
    localparam int CMD_IE_BIT    = 8;
    localparam int CMD_CLRV_BIT  = 2;

    // descriptor word indices
    localparam logic [2:0] W_CMD0 = 3'd0;
    localparam logic [2:0] W_CMD1 = 3'd1;
    localparam logic [2:0] W_SRC  = 3'd2;
    localparam logic [2:0] W_DST  = 3'd4;
    localparam logic [2:0] W_STAT = 3'd6;
    localparam logic [2:0] W_NEXT = 3'd7;

    // Order in which descriptor words are read; unused words are skipped.
    function automatic logic [2:0] next_word(input logic [2:0] idx);
        case (idx)
            W_CMD0:  next_word = W_CMD1;
            W_CMD1:  next_word = W_SRC;
            W_SRC:   next_word = W_DST;
            W_DST:   next_word = W_NEXT;
            default: next_word = W_CMD0;
        endcase
    endfunction

endpackage

// File: rtl/cdma_wb_fmt.sv
`timescale 1ns/1ps
// Builds the word written to the descriptor status slot from the
// command word's write-back select field. Purely combinational.
// Assumes the select field sits in command bits 1:0.
module cdma_wb_fmt
    import chain_dma_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic [31:0]      cmd0,
    input  logic [CNT_W-1:0] remain,
    input  logic [2:0]       chstat,
    output logic [31:0]      word
);

    wb_sel_e sel;
    assign sel = wb_sel_e'(cmd0[1:0]);

    // select the write-back payload
    always_comb begin
        case (sel)
            WB_CHSTAT: word = {29'd0, chstat};
            WB_CMD:    word = cmd0 & ~(32'd1 << CMD_VALID_BIT);
            WB_REMAIN: word = {{(32-CNT_W){1'b0}}, remain};
            default:   word = 32'd0;
        endcase
    end

endmodule

// File: rtl/cdma_regs.sv
`timescale 1ns/1ps
// Software-visible registers of the channel: enable, descriptor pointer,
// doorbell, pending flag, status and residual count. The sequencer
// updates pointer, pending flag and count when a descriptor retires.
// Assumes NXT_W + SHIFT equals 32.
module cdma_regs
    import chain_dma_pkg::*;
#(
    parameter int NXT_W = 27,
    parameter int SHIFT = 5,
    parameter int CNT_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               bell_take,
    input  logic               ptr_adv,
    input  logic [NXT_W-1:0]   ptr_next,
    input  logic               done_set,
    input  logic               done_ie,
    input  logic [CNT_W-1:0]   done_remain,
    input  logic               halted,
    input  logic               dvalid,
    output logic               chan_en,
    output logic               bell_pend,
    output logic [NXT_W+SHIFT-1:0] desc_ptr,
    output logic               irq_pend,
    output logic               irq_ie
);

    localparam int ADDR_W = NXT_W + SHIFT;

    logic [NXT_W-1:0] ptr_idx;
    logic [CNT_W-1:0] bytecnt;
    logic             wr_cfg, wr_ptr, wr_bell, wr_irq;
    logic [SHIFT-2:0] unused_wbits;

    assign wr_cfg  = reg_we && (reg_addr == RA_CFG);
    assign wr_ptr  = reg_we && (reg_addr == RA_PTR);
    assign wr_bell = reg_we && (reg_addr == RA_BELL);
    assign wr_irq  = reg_we && (reg_addr == RA_IRQ);
    assign unused_wbits = reg_wdata[SHIFT-1:1];

    assign desc_ptr = {ptr_idx, {SHIFT{1'b0}}};

    // channel enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)      chan_en <= 1'b0;
        else if (wr_cfg) chan_en <= reg_wdata[0];
    end

    // descriptor pointer: the engine's advance wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_idx <= '0;
        else if (ptr_adv) ptr_idx <= ptr_next;
        else if (wr_ptr)  ptr_idx <= reg_wdata[SHIFT +: NXT_W];
    end

    // doorbell flag: a new ring wins over the engine consuming the old one
    always_ff @(posedge clk) begin
        if (!rst_n)         bell_pend <= 1'b0;
        else if (wr_bell)   bell_pend <= 1'b1;
        else if (bell_take) bell_pend <= 1'b0;
    end

    // pending flag, set on retire, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n)                      irq_pend <= 1'b0;
        else if (done_set)               irq_pend <= 1'b1;
        else if (wr_irq && reg_wdata[0]) irq_pend <= 1'b0;
    end

    // interrupt enable and residual count of the last retired descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_ie  <= 1'b0;
            bytecnt <= '0;
        end else if (done_set) begin
            irq_ie  <= done_ie;
            bytecnt <= done_remain;
        end
    end

    // register read multiplexer
    always_comb begin
        case (reg_addr)
            RA_CFG:  reg_rdata = {31'd0, chan_en};
            RA_PTR:  reg_rdata = 32'(desc_ptr);
            RA_IRQ:  reg_rdata = {31'd0, irq_pend};
            RA_STAT: reg_rdata = {29'd0, bell_pend, dvalid, halted};
            RA_BCNT: reg_rdata = {{(32-CNT_W){1'b0}}, bytecnt};
            default: reg_rdata = 32'd0;
        endcase
    end

    // ADDR_W kept for readers checking the pointer width
    logic [ADDR_W-1:0] unused_ptr_w;
    assign unused_ptr_w = desc_ptr;

endmodule

// File: rtl/cdma_seq.sv
`timescale 1ns/1ps
// Descriptor walker: fetches the needed words of the current descriptor,
// launches the data mover, performs the requested write-backs and
// retires the descriptor before following the next pointer.
// Assumes read data arrives in the grant cycle and that the mover
// raises mv_done exactly once per mv_start.
module cdma_seq
    import chain_dma_pkg::*;
#(
    parameter int NXT_W = 27,
    parameter int SHIFT = 5,
    parameter int CNT_W = 22
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   chan_en,
    input  logic                   bell_pend,
    input  logic [NXT_W+SHIFT-1:0] desc_ptr,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [NXT_W+SHIFT-1:0] mem_addr,
    output logic [31:0]            mem_wdata,
    input  logic                   mem_gnt,
    input  logic [31:0]            mem_rdata,
    output logic                   mv_start,
    output logic [31:0]            mv_src,
    output logic [31:0]            mv_dst,
    output logic [CNT_W-1:0]       mv_count,
    input  logic                   mv_done,
    input  logic [CNT_W-1:0]       mv_remain,
    output logic                   bell_take,
    output logic                   halted,
    output logic                   dvalid,
    output logic                   ptr_adv,
    output logic [NXT_W-1:0]       ptr_next,
    output logic                   done_set,
    output logic                   done_ie,
    output logic [CNT_W-1:0]       done_remain
);

    localparam int ADDR_W = NXT_W + SHIFT;

    seq_state_e        state;
    logic [2:0]        widx;
    logic [31:0]       cmd0;
    logic [CNT_W-1:0]  remain_q;
    logic [NXT_W-1:0]  nxt;
    logic [31:0]       wb_word;
    logic              want_stat, want_clr;

    assign want_stat = (cmd0[1:0] != WB_NONE);
    assign want_clr  = cmd0[CMD_CLRV_BIT];

    cdma_wb_fmt #(.CNT_W(CNT_W)) u_fmt (
        .cmd0   (cmd0),
        .remain (remain_q),
        .chstat ({bell_pend, dvalid, halted}),
        .word   (wb_word)
    );

    // state sequencing and descriptor field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            widx     <= W_CMD0;
            cmd0     <= '0;
            mv_count <= '0;
            mv_src   <= '0;
            mv_dst   <= '0;
            nxt      <= '0;
            remain_q <= '0;
            halted   <= 1'b0;
            dvalid   <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (bell_take) begin
                        state  <= SQ_FETCH;
                        widx   <= W_CMD0;
                        halted <= 1'b0;
                    end
                end
                SQ_FETCH: begin
                    if (mem_gnt) begin
                        widx <= next_word(widx);
                        case (widx)
                            W_CMD0: begin
                                if (!mem_rdata[CMD_VALID_BIT]) begin
                                    halted <= 1'b1;
                                    dvalid <= 1'b0;
                                    state  <= SQ_IDLE;
                                end else begin
                                    cmd0   <= mem_rdata;
                                    dvalid <= 1'b1;
                                end
                            end
                            W_CMD1: mv_count <= mem_rdata[CNT_W-1:0];
                            W_SRC:  mv_src   <= mem_rdata;
                            W_DST:  mv_dst   <= mem_rdata;
                            W_NEXT: begin
                                nxt   <= mem_rdata[NXT_W-1:0];
                                state <= SQ_LAUNCH;
                            end
                            default: ;
                        endcase
                    end
                end
                SQ_LAUNCH: state <= SQ_MOVE;
                SQ_MOVE: begin
                    if (mv_done) begin
                        remain_q <= mv_remain;
                        if (want_stat)     state <= SQ_WB_STAT;
                        else if (want_clr) state <= SQ_WB_CLR;
                        else               state <= SQ_RETIRE;
                    end
                end
                SQ_WB_STAT: begin
                    if (mem_gnt) state <= want_clr ? SQ_WB_CLR : SQ_RETIRE;
                end
                SQ_WB_CLR: begin
                    if (mem_gnt) state <= SQ_RETIRE;
                end
                SQ_RETIRE: begin
                    dvalid <= 1'b0;
                    widx   <= W_CMD0;
                    state  <= chan_en ? SQ_FETCH : SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // memory port drive
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_ptr;
        mem_wdata = 32'd0;
        case (state)
            SQ_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr + ADDR_W'({widx, 2'b00});
            end
            SQ_WB_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_ptr + ADDR_W'({W_STAT, 2'b00});
                mem_wdata = wb_word;
            end
            SQ_WB_CLR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = cmd0 & ~(32'd1 << CMD_VALID_BIT);
            end
            default: ;
        endcase
    end

    // handshakes towards the mover and the register file
    assign mv_start    = (state == SQ_LAUNCH);
    assign bell_take   = (state == SQ_IDLE) && chan_en && bell_pend;
    assign done_set    = (state == SQ_RETIRE);
    assign ptr_adv     = (state == SQ_RETIRE);
    assign ptr_next    = nxt;
    assign done_ie     = cmd0[CMD_IE_BIT];
    assign done_remain = remain_q;

endmodule

// File: rtl/chain_dma_seq.sv
`timescale 1ns/1ps
// Top of the linked-descriptor DMA channel sequencer: register file plus
// descriptor walker. The interrupt is the pending flag qualified by the
// enable bit of the last retired descriptor.
// Assumes a single outstanding memory access and one mover.
module chain_dma_seq #(
    parameter int NXT_W = 27,
    parameter int SHIFT = 5,
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_gnt,
    input  logic [31:0]      mem_rdata,
    output logic             mv_start,
    output logic [31:0]      mv_src,
    output logic [31:0]      mv_dst,
    output logic [CNT_W-1:0] mv_count,
    input  logic             mv_done,
    input  logic [CNT_W-1:0] mv_remain,
    output logic             irq_out
);

    localparam int ADDR_W = NXT_W + SHIFT;

    logic              chan_en, bell_pend, bell_take;
    logic              halted, dvalid;
    logic              ptr_adv, done_set, done_ie;
    logic [NXT_W-1:0]  ptr_next;
    logic [CNT_W-1:0]  done_remain;
    logic [ADDR_W-1:0] desc_ptr;
    logic [ADDR_W-1:0] seq_addr;
    logic              irq_pend, irq_ie;

    cdma_regs #(.NXT_W(NXT_W), .SHIFT(SHIFT), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .bell_take   (bell_take),
        .ptr_adv     (ptr_adv),
        .ptr_next    (ptr_next),
        .done_set    (done_set),
        .done_ie     (done_ie),
        .done_remain (done_remain),
        .halted      (halted),
        .dvalid      (dvalid),
        .chan_en     (chan_en),
        .bell_pend   (bell_pend),
        .desc_ptr    (desc_ptr),
        .irq_pend    (irq_pend),
        .irq_ie      (irq_ie)
    );

    cdma_seq #(.NXT_W(NXT_W), .SHIFT(SHIFT), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_en     (chan_en),
        .bell_pend   (bell_pend),
        .desc_ptr    (desc_ptr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (seq_addr),
        .mem_wdata   (mem_wdata),
        .mem_gnt     (mem_gnt),
        .mem_rdata   (mem_rdata),
        .mv_start    (mv_start),
        .mv_src      (mv_src),
        .mv_dst      (mv_dst),
        .mv_count    (mv_count),
        .mv_done     (mv_done),
        .mv_remain   (mv_remain),
        .bell_take   (bell_take),
        .halted      (halted),
        .dvalid      (dvalid),
        .ptr_adv     (ptr_adv),
        .ptr_next    (ptr_next),
        .done_set    (done_set),
        .done_ie     (done_ie),
        .done_remain (done_remain)
    );

    assign mem_addr = 32'(seq_addr);

    // interrupt line
    assign irq_out = irq_pend & irq_ie;

endmodule

// File: rtl/cdma_chk.sv
`timescale 1ns/1ps
// Protocol and ordering checks for chain_dma_seq, bound to the top.
module cdma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_gnt,
    input logic [31:0] mem_addr,
    input logic        mv_start,
    input logic        mv_done,
    input logic        halted,
    input logic        done_set,
    input logic        irq_pend
);

    logic busy;

    // tracks the mover being active between start and done
    always_ff @(posedge clk) begin
        if (!rst_n)        busy <= 1'b0;
        else if (mv_start) busy <= 1'b1;
        else if (mv_done)  busy <= 1'b0;
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R11
    quiet_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_req);

    // R5
    wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_addr[4:0] == 5'd0) || (mem_addr[4:0] == 5'd24));

    // R4
    halt_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mv_start);

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start);

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> irq_pend);

endmodule

bind chain_dma_seq cdma_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .mv_start (mv_start),
    .mv_done  (mv_done),
    .halted   (halted),
    .done_set (done_set),
    .irq_pend (irq_pend)
);

// File: tb/chain_dma_seq_test.sv
`timescale 1ns/1ps
module chain_dma_seq_test;

    localparam int MEMW = 144;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        mv_start;
    logic [31:0] mv_src, mv_dst;
    logic [21:0] mv_count;
    logic        mv_done = 1'b0;
    logic [21:0] mv_remain = 22'd0;
    logic        irq_out;

    logic [31:0] mem [MEMW];
    int checks = 0;
    int fails  = 0;
    int starts = 0;

    always #10 clk = ~clk;

    chain_dma_seq uut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_count(mv_count),
        .mv_done(mv_done), .mv_remain(mv_remain), .irq_out(irq_out)
    );

    // expected descriptor contents
    function automatic logic [1:0] e_st(input int k);
        return (k == 16) ? 2'd3 : 2'(k);
    endfunction
    function automatic logic e_cv(input int k);
        return (k == 16) ? 1'b1 : k[2];
    endfunction
    function automatic logic e_ie(input int k);
        return (k == 16) ? 1'b0 : k[3];
    endfunction
    function automatic logic [31:0] e_cmd0(input int k);
        return 32'h8000_0000 | (32'(k) << 20) | (32'(e_ie(k)) << 8)
             | (32'(e_cv(k)) << 2) | 32'(e_st(k));
    endfunction
    function automatic logic [31:0] e_cnt(input int k);
        return 32'(16 + 7 * k);
    endfunction
    function automatic logic [31:0] e_src(input int k);
        return 32'h1000_0000 + 32'(k) * 32'd256;
    endfunction
    function automatic logic [31:0] e_dst(input int k);
        return 32'h2000_0000 + 32'(k) * 32'd64;
    endfunction
    function automatic logic [31:0] e_w6(input int k);
        case (e_st(k))
            2'd1:    return 32'd2;
            2'd2:    return e_cmd0(k) & 32'h7FFF_FFFF;
            2'd3:    return 32'(k);
            default: return 32'h5A5A_0000 | 32'(k);
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_halt();
        logic [31:0] s;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 20000; i++) begin
            reg_read(3'd4, s);
            if (s[0]) break;
        end
    endtask

    task automatic put_desc(input int k, input logic valid);
        mem[k*8+0] = valid ? e_cmd0(k) : 32'd0;
        mem[k*8+1] = 32'hA000_0000 | e_cnt(k);
        mem[k*8+2] = e_src(k);
        mem[k*8+3] = 32'hCCCC_0003;
        mem[k*8+4] = e_dst(k);
        mem[k*8+5] = 32'hCCCC_0005;
        mem[k*8+6] = 32'h5A5A_0000 | 32'(k);
        mem[k*8+7] = 32'hF800_0000 | 32'(k + 1);
    endtask

    // memory responder: grant latency 0..2 cycles by word address
    initial begin
        int wcnt;
        wcnt = 0;
        forever begin
            @(negedge clk);
            if (mem_gnt) begin
                mem_gnt = 1'b0;
                wcnt = 0;
            end else if (mem_req) begin
                if (wcnt >= int'(mem_addr[4:2]) % 3) begin
                    int idx;
                    idx = int'(mem_addr >> 2);
                    mem_gnt = 1'b1;
                    if (idx < MEMW) begin
                        if (mem_we) mem[idx] = mem_wdata;
                        else        mem_rdata = mem[idx];
                    end else begin
                        mem_rdata = 32'd0;
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // mover model: checks the launch, then reports done with remain = index
    initial begin
        forever begin
            @(negedge clk);
            if (mv_start) begin
                int k;
                k = starts;
                starts++;
                check("R3 mover source", mv_src, e_src(k));
                check("R3 mover destination", mv_dst, e_dst(k));
                check("R3 mover count", 32'(mv_count), e_cnt(k) & 32'h003F_FFFF);
                check("R8 irq_out at launch", 32'(irq_out),
                      (k == 0 || k == 16) ? 32'd0 : 32'(e_ie(k - 1)));
                repeat (1 + k % 3) @(negedge clk);
                mv_done = 1'b1;
                mv_remain = 22'(k);
                @(negedge clk);
                mv_done = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int k = 0; k < 16; k++) put_desc(k, 1'b1);
        put_desc(16, 1'b0);
        put_desc(17, 1'b0);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            reg_read(3'(a), v);
            check("R1 register after reset", v, 32'd0);
        end
        check("R1 mem_req after reset", 32'(mem_req), 32'd0);
        check("R1 mv_start after reset", 32'(mv_start), 32'd0);
        check("R1 irq_out after reset", 32'(irq_out), 32'd0);

        // R9 pointer ignores low address bits
        reg_write(3'd1, 32'h0000_001F);
        reg_read(3'd1, v);
        check("R9 pointer low bits dropped", v, 32'd0);

        // R2 doorbell while disabled
        reg_write(3'd2, 32'h1234_5678);
        repeat (30) @(negedge clk);
        reg_read(3'd4, v);
        check("R2 doorbell bit set, not started", v, 32'd4);
        check("R2 no launch while disabled", 32'(starts), 32'd0);

        // enable: chain of 16 runs and stops on descriptor 16
        reg_write(3'd0, 32'd1);
        wait_halt();
        check("R9 all chained descriptors launched", 32'(starts), 32'd16);
        reg_read(3'd4, v);
        check("R4 halted status", v, 32'd1);
        reg_read(3'd1, v);
        check("R9 pointer at invalid descriptor", v, 32'd512);
        reg_read(3'd5, v);
        check("R10 residual count", v, 32'd15);
        reg_read(3'd3, v);
        check("R7 pending set", v, 32'd1);
        check("R8 irq_out with enable", 32'(irq_out), 32'd1);
        for (int k = 0; k < 16; k++) begin
            check($sformatf("R5 status word desc %0d", k), mem[k*8+6], e_w6(k));
            check($sformatf("R6 command word desc %0d", k), mem[k*8],
                  e_cv(k) ? (e_cmd0(k) & 32'h7FFF_FFFF) : e_cmd0(k));
        end

        // R7 write 0 keeps, write 1 clears
        reg_write(3'd3, 32'd0);
        reg_read(3'd3, v);
        check("R7 write zero keeps pending", v, 32'd1);
        reg_write(3'd3, 32'd1);
        reg_read(3'd3, v);
        check("R7 write one clears pending", v, 32'd0);
        check("R8 irq_out after clear", 32'(irq_out), 32'd0);

        // R4 doorbell on a still-invalid descriptor
        reg_write(3'd2, 32'd0);
        wait_halt();
        check("R4 no launch on invalid", 32'(starts), 32'd16);
        reg_read(3'd1, v);
        check("R4 pointer unchanged", v, 32'd512);
        reg_read(3'd4, v);
        check("R4 halted again", v, 32'd1);

        // R4 repaired descriptor is fetched from the same pointer
        mem[128] = e_cmd0(16);
        reg_write(3'd2, 32'd0);
        wait_halt();
        check("R4 restart launched", 32'(starts), 32'd17);
        reg_read(3'd1, v);
        check("R9 pointer after restart", v, 32'd544);
        check("R5 remaining count written", mem[134], 32'd16);
        check("R6 valid cleared", mem[128], e_cmd0(16) & 32'h7FFF_FFFF);
        reg_read(3'd5, v);
        check("R10 residual after restart", v, 32'd16);
        reg_read(3'd3, v);
        check("R7 pending without enable", v, 32'd1);
        check("R8 irq_out masked", 32'(irq_out), 32'd0);

        summary();
        $finish;
    end

endmodule